// File: doc/BRIEF.md
# Stuck-Bus Timeout and Alert Manager

This block watches the two shared downstream clock and data nodes of a bus multiplexer for a line that stays low. It counts how long that lasts in ticks of a prescaled clock, and when the time passes a limit chosen by two mode bits it reports a timeout and asks the connection buffers to turn off. It also gathers the per-channel alert inputs and a failed-connection event. All of these sources drive a single active-low ALERT output.

There are two latched paths into ALERT. One carries the channel and connection faults, the other carries the stuck-bus timeout. Answering the alert-response address or being addressed releases ALERT. It is not driven low again until a fault of a different kind appears, or until the original fault goes away and comes back. A fault-clear pulse, which marks a write to the status register, clears every latch. When the enable input is low, the timer, the flags and the connection latch return to their reset state, and bus events are ignored. The channel alert inputs still reach ALERT in that state.

Top module: `stuck_alert_mgr`

## Requirements
- R1: After reset, with both nodes high and all channel alerts high, alert_n=1, tmo_live=0, tmo_latched=0 and buf_off=0.
- R2: While enable=1 and sda_low or scl_low is 1, the timer counts ticks of TICK_DIV cycles. tmo_live rises once the count reaches LIM_LONG ticks for tmo_mode=2'b01, LIM_MID for 2'b10, or LIM_SHORT for 2'b11.
- R3: With tmo_mode=2'b00 the timer is off and tmo_live never rises, however long a node stays low.
- R4: The count is cleared only when sda_high and scl_high are both 1, and tmo_live then drops. When no node is low and not both are high, the count holds its value.
- R5: A timeout sets tmo_latched and buf_off and drives alert_n low. tmo_latched and buf_off stay at 1 until fault_clr.
- R6: While tmo_latched=1, a further timeout does not drive alert_n low again after a release.
- R7: A channel alert input at 0 drives alert_n low. A conn_fail pulse is latched and also drives alert_n low.
- R8: An ara_ack or addr_hit pulse sets alert_n to 1. alert_n stays at 1 while the same faults persist. A new kind of fault, or a channel alert that goes high and then low again, drives alert_n low again.
- R9: fault_clr clears all latches. A fault that is still present, or that recurs after the clear, drives alert_n low again.
- R10: With enable=0, the timer, tmo_live, tmo_latched, buf_off and the connection latch are cleared, and conn_fail, fault_clr and release pulses are ignored. Channel alerts still drive alert_n low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; low returns the block to defaults |
| sda_low | input | 1 | Shared data node below the low threshold |
| scl_low | input | 1 | Shared clock node below the low threshold |
| sda_high | input | 1 | Shared data node above the high threshold |
| scl_high | input | 1 | Shared clock node above the high threshold |
| ch_alert_n | input | NCH | Active-low channel alert inputs |
| conn_fail | input | 1 | Pulse: a connection attempt failed |
| fault_clr | input | 1 | Pulse: clear all fault latches |
| ara_ack | input | 1 | Pulse: alert-response address answered |
| addr_hit | input | 1 | Pulse: block was addressed |
| tmo_mode | input | 2 | Timeout limit select |
| alert_n | output | 1 | Active-low merged alert |
| tmo_live | output | 1 | Real-time timeout flag |
| tmo_latched | output | 1 | Latched timeout flag |
| buf_off | output | 1 | Request to turn off the connection buffers |

## Verification
The bench checks the timeout edge on both sides of the tick window for every mode. A timer that counts cycles or uses the wrong limit would fire early or late. It separates the hold band from the release band: a design that clears the count whenever no node is low would lose the accumulated time. It drives release, a new fault kind, a recurring channel alert and a repeated timeout while the latch is set. A design that re-arms on every event would pull ALERT low again when it should stay quiet, and one that never re-arms would miss the new fault. With enable low, it confirms that bus events are ignored while channel alerts still reach ALERT.

// File: rtl/sam_pkg.sv
package sam_pkg;
  typedef enum logic [1:0] {
    TMO_OFF   = 2'b00,
    TMO_LONG  = 2'b01,
    TMO_MID   = 2'b10,
    TMO_SHORT = 2'b11
  } tmo_sel_e;
endpackage

// File: rtl/sam_tick.sv
module sam_tick #(
  parameter int TICK_DIV = 50000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = (cnt_q == LAST);
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sam_stuck_timer.sv
module sam_stuck_timer
  import sam_pkg::*;
#(
  parameter int LIM_LONG  = 60,
  parameter int LIM_MID   = 30,
  parameter int LIM_SHORT = 15
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     en,
  input  logic     tick,
  input  tmo_sel_e mode,
  input  logic     any_low,
  input  logic     all_high,
  input  logic     clr,
  input  logic     rel,
  output logic     live,
  output logic     latched,
  output logic     pend
);
  localparam int LMAX = (LIM_LONG > LIM_MID) ? ((LIM_LONG > LIM_SHORT) ? LIM_LONG : LIM_SHORT)
                                              : ((LIM_MID > LIM_SHORT) ? LIM_MID : LIM_SHORT);
  localparam int CW = $clog2(LMAX + 1);

  logic [CW-1:0] cnt_q, cnt_d, lim;
  logic          live_q, live_d, lat_q, lat_d, pend_q, pend_d;
  logic          run, evt;

  always_comb begin
    case (mode)
      TMO_LONG:  lim = CW'(LIM_LONG);
      TMO_MID:   lim = CW'(LIM_MID);
      TMO_SHORT: lim = CW'(LIM_SHORT);
      default:   lim = '0;
    endcase
    run = en && (mode != TMO_OFF);
    if (!run || all_high)                      cnt_d = '0;
    else if (any_low && tick && (cnt_q < lim)) cnt_d = cnt_q + 1'b1;
    else                                       cnt_d = cnt_q;
    live_d = run && !all_high && (cnt_d >= lim);
    evt    = live_d && !live_q;
    if (!en)       lat_d = 1'b0;
    else if (evt)  lat_d = 1'b1;
    else if (clr)  lat_d = 1'b0;
    else           lat_d = lat_q;
    if (!en)                pend_d = 1'b0;
    else if (evt && !lat_q) pend_d = 1'b1;
    else if (clr || rel)    pend_d = 1'b0;
    else                    pend_d = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      live_q <= 1'b0;
      lat_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      live_q <= live_d;
      lat_q  <= lat_d;
      pend_q <= pend_d;
    end
  end

  assign live    = live_q;
  assign latched = lat_q;
  assign pend    = pend_q;

  assert_release_band_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (all_high) |=> !live_q);
  assert_mode_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == TMO_OFF) |=> !live_q);
  assert_latch_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_q && en && !clr) |=> lat_q);
  assert_timeout_latches_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(live_q) |-> lat_q);
  assert_no_rearm_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_q && !pend_q && en) |=> !pend_q);
endmodule

// File: rtl/sam_alert_group.sv
module sam_alert_group #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic [NCH-1:0] ch_alert_n,
  input  logic           conn_fail,
  input  logic           clr,
  input  logic           rel,
  output logic           pend
);
  localparam int NK = NCH + 1;

  logic          conn_q, conn_d;
  logic [NK-1:0] kinds, seen_q, seen_d;
  logic          clr_e, rel_e;

  always_comb begin
    clr_e = en && clr;
    rel_e = en && rel;
    if (!en)            conn_d = 1'b0;
    else if (conn_fail) conn_d = 1'b1;
    else if (clr)       conn_d = 1'b0;
    else                conn_d = conn_q;
    kinds = {conn_q, ~ch_alert_n};
    pend  = |(kinds & ~seen_q);
  end

  for (genvar k = 0; k < NK; k++) begin : g_seen
    always_comb begin
      if (clr_e) seen_d[k] = 1'b0;
      else       seen_d[k] = kinds[k] && (seen_q[k] || rel_e);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conn_q <= 1'b0;
      seen_q <= '0;
    end else begin
      conn_q <= conn_d;
      seen_q <= seen_d;
    end
  end

  assert_conn_cleared_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!en) |=> !conn_q);
  assert_conn_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && conn_fail) |=> conn_q);
endmodule

// File: rtl/stuck_alert_mgr.sv
module stuck_alert_mgr
  import sam_pkg::*;
#(
  parameter int NCH       = 2,
  parameter int TICK_DIV  = 50000,
  parameter int LIM_LONG  = 60,
  parameter int LIM_MID   = 30,
  parameter int LIM_SHORT = 15
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           enable,
  input  logic           sda_low,
  input  logic           scl_low,
  input  logic           sda_high,
  input  logic           scl_high,
  input  logic [NCH-1:0] ch_alert_n,
  input  logic           conn_fail,
  input  logic           fault_clr,
  input  logic           ara_ack,
  input  logic           addr_hit,
  input  logic [1:0]     tmo_mode,
  output logic           alert_n,
  output logic           tmo_live,
  output logic           tmo_latched,
  output logic           buf_off
);
  logic tick, any_low, all_high, rel;
  logic stuck_pend, grp_pend;
  logic alert_q, alert_d;

  assign any_low  = sda_low | scl_low;
  assign all_high = sda_high & scl_high;
  assign rel      = ara_ack | addr_hit;

  sam_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  sam_stuck_timer #(
    .LIM_LONG(LIM_LONG), .LIM_MID(LIM_MID), .LIM_SHORT(LIM_SHORT)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .en(enable), .tick(tick),
    .mode(tmo_sel_e'(tmo_mode)), .any_low(any_low), .all_high(all_high),
    .clr(fault_clr), .rel(rel),
    .live(tmo_live), .latched(tmo_latched), .pend(stuck_pend)
  );

  sam_alert_group #(.NCH(NCH)) u_group (
    .clk(clk), .rst_n(rst_n), .en(enable), .ch_alert_n(ch_alert_n),
    .conn_fail(conn_fail), .clr(fault_clr), .rel(rel), .pend(grp_pend)
  );

  always_comb alert_d = grp_pend | stuck_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) alert_q <= 1'b0;
    else        alert_q <= alert_d;
  end

  assign alert_n = ~alert_q;
  assign buf_off = tmo_latched;

  assert_bufoff_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_live) |-> buf_off);
endmodule

// File: tb/tb_stuck_alert_mgr.sv
module tb_stuck_alert_mgr;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;
  localparam int LL = 12, LM = 6, LS = 3;

  logic clk = 1'b0;
  logic rst_n, enable, sda_low, scl_low, sda_high, scl_high;
  logic [1:0] ch_alert_n, tmo_mode;
  logic conn_fail, fault_clr, ara_ack, addr_hit;
  logic alert_n, tmo_live, tmo_latched, buf_off;
  int tests = 0, failed = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stuck_alert_mgr #(.NCH(2), .TICK_DIV(DIV), .LIM_LONG(LL), .LIM_MID(LM), .LIM_SHORT(LS)) dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .sda_low(sda_low), .scl_low(scl_low),
    .sda_high(sda_high), .scl_high(scl_high), .ch_alert_n(ch_alert_n),
    .conn_fail(conn_fail), .fault_clr(fault_clr), .ara_ack(ara_ack), .addr_hit(addr_hit),
    .tmo_mode(tmo_mode), .alert_n(alert_n), .tmo_live(tmo_live),
    .tmo_latched(tmo_latched), .buf_off(buf_off)
  );

  function automatic int lim_of(int m);
    return (m == 1) ? LL : (m == 2) ? LM : (m == 3) ? LS : 0;
  endfunction

  task automatic chk(string req, logic act, logic exp);
    tests++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic wt(int n);
    repeat (n) @(negedge clk);
  endtask

  // 0 = stuck low, 1 = between thresholds, 2 = both high
  task automatic nodes(int s);
    sda_low  = (s == 0);
    scl_low  = 1'b0;
    sda_high = (s == 2);
    scl_high = (s != 0);
  endtask

  task automatic pulse_clr();  fault_clr = 1; wt(1); fault_clr = 0; wt(3); endtask
  task automatic pulse_ara();  ara_ack   = 1; wt(1); ara_ack   = 0; wt(3); endtask
  task automatic pulse_hit();  addr_hit  = 1; wt(1); addr_hit  = 0; wt(3); endtask
  task automatic pulse_conn(); conn_fail = 1; wt(1); conn_fail = 0; wt(3); endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failed++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, failed);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4305));
    rst_n = 0; enable = 1; nodes(2); ch_alert_n = 2'b11; tmo_mode = 2'b00;
    conn_fail = 0; fault_clr = 0; ara_ack = 0; addr_hit = 0;
    wt(3); rst_n = 1; wt(2);

    chk("R1 alert_n", alert_n, 1'b1);
    chk("R1 live", tmo_live, 1'b0);
    chk("R1 latched", tmo_latched, 1'b0);
    chk("R1 buf_off", buf_off, 1'b0);

    // R3 disabled mode
    nodes(0); wt(80);
    chk("R3 live", tmo_live, 1'b0);
    chk("R3 alert_n", alert_n, 1'b1);
    nodes(2); wt(3);

    // R2 each limit, R5 latch, R4 release
    for (int m = 1; m <= 3; m++) begin
      tmo_mode = m[1:0];
      nodes(0); wt((lim_of(m) - 1) * DIV - 1);
      chk("R2 before limit", tmo_live, 1'b0);
      wt(DIV + 3);
      chk("R2 after limit", tmo_live, 1'b1);
      chk("R5 latched", tmo_latched, 1'b1);
      chk("R5 buf_off", buf_off, 1'b1);
      chk("R5 alert_n", alert_n, 1'b0);
      nodes(2); wt(3);
      chk("R4 live drops", tmo_live, 1'b0);
      chk("R5 latched holds", tmo_latched, 1'b1);
      pulse_clr();
      chk("R9 latched clear", tmo_latched, 1'b0);
      chk("R9 alert released", alert_n, 1'b1);
    end

    // R4 hold band versus release band
    tmo_mode = 2'b11;
    nodes(0); wt(8); nodes(1); wt(20); nodes(0); wt(6);
    chk("R4 hold keeps count", tmo_live, 1'b1);
    nodes(2); wt(3); pulse_clr();
    nodes(0); wt(8); nodes(2); wt(20); nodes(0); wt(6);
    chk("R4 release clears count", tmo_live, 1'b0);
    nodes(2); wt(3); pulse_clr();

    // R6 no re-arm while latched
    nodes(0); wt(16);
    chk("R5 stuck alert", alert_n, 1'b0);
    pulse_ara();
    chk("R8 ara releases", alert_n, 1'b1);
    nodes(2); wt(3); nodes(0); wt(16);
    chk("R6 second timeout live", tmo_live, 1'b1);
    chk("R6 stays released", alert_n, 1'b1);
    nodes(2); wt(3); pulse_clr();
    chk("R9 buf_off clear", buf_off, 1'b0);
    nodes(0); wt(16);
    chk("R9 recurrence alerts", alert_n, 1'b0);
    nodes(2); wt(3); pulse_clr(); tmo_mode = 2'b00;

    // R7 / R8 channel and connection path
    ch_alert_n = 2'b10; wt(3);
    chk("R7 channel alert", alert_n, 1'b0);
    pulse_hit();
    chk("R8 addr_hit releases", alert_n, 1'b1);
    ch_alert_n = 2'b00; wt(3);
    chk("R8 new kind reasserts", alert_n, 1'b0);
    pulse_ara();
    chk("R8 released again", alert_n, 1'b1);
    pulse_conn();
    chk("R7 conn fault", alert_n, 1'b0);
    pulse_ara();
    ch_alert_n = 2'b01; wt(3);
    chk("R8 same fault quiet", alert_n, 1'b1);
    ch_alert_n = 2'b00; wt(3);
    chk("R8 recurring channel", alert_n, 1'b0);
    ch_alert_n = 2'b11; pulse_clr();
    chk("R9 all clear", alert_n, 1'b1);

    // R10 enable low
    enable = 0; wt(2);
    pulse_conn();
    chk("R10 conn ignored", alert_n, 1'b1);
    ch_alert_n = 2'b10; wt(3);
    chk("R10 channel passes", alert_n, 1'b0);
    pulse_ara();
    chk("R10 release ignored", alert_n, 1'b0);
    ch_alert_n = 2'b11; wt(3);
    enable = 1; tmo_mode = 2'b11; nodes(0); wt(16);
    chk("R10 setup latched", tmo_latched, 1'b1);
    enable = 0; wt(3);
    chk("R10 latched cleared", tmo_latched, 1'b0);
    chk("R10 buf_off cleared", buf_off, 1'b0);
    chk("R10 live cleared", tmo_live, 1'b0);
    chk("R10 alert cleared", alert_n, 1'b1);
    nodes(2); enable = 1; tmo_mode = 2'b00; wt(3);

    // random channel patterns
    for (int i = 0; i < 24; i++) begin
      logic [1:0] p;
      p = 2'($urandom % 4);
      ch_alert_n = p;
      pulse_clr();
      chk("R7 random pattern", alert_n, (p == 2'b11));
      if ($urandom % 2) pulse_ara(); else pulse_hit();
      chk("R8 random release", alert_n, 1'b1);
    end
    ch_alert_n = 2'b11; wt(3);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end
endmodule